// File: doc/BRIEF.md
# Eight-Stage Pipeline Interlock

This block decides, every cycle, whether the instruction sitting in the decode/operand-fetch stage of an in-order eight-stage pipeline may move on. The stages are fetch, decode, execute, four memory-access stages (M0 to M3) and writeback. The block compares the decode instruction's two source registers and category with the destination, write-enable, category and exception-enable flag of the instructions in execute and in each memory stage. It then drives a small set of freeze and bubble controls for the surrounding pipeline registers.

Three kinds of interlock are covered. The first is read-after-write hazards, whose length follows from the producer's category and its current stage. The second is structural interlocks for stream instructions and for memory instructions in M0 that sit behind instructions able to raise exceptions. The third is holding the execute stage while a multi-cycle operation is still busy. Forwarding, the register file and the functional units lie outside the block.

Top module: `pipe_interlock`

## Requirements
- R1: Categories are coded ALU=0, barrel shift=1, multiply=2, load=3, store=4, divide=5, short floating point=6, long floating point (divide, float-to-int, square root)=7, stream=8. Downstream stages are indexed EX=0, M0=1, M1=2, M2=3, M3=4. A producer in stage s whose destination matches a decode source stalls decode (`stall_front`) while s is below its availability index: ALU 0, shift 1, store 1, multiply 2, load/divide/floating point 5, stream 0.
- R2: A producer with write-enable low, or with destination register 0, never causes a data stall.
- R3: A match on either decode source (`of_src_a` or `of_src_b`) is enough to cause the data stall.
- R4: Whenever decode is stalled and execute is not frozen, `bubble_ex` is high. `bubble_ex` is never high while `hold_ex` is high.
- R5: A stream instruction in decode stalls when EX holds a stream, load, store, divide or floating-point instruction whose exception flag is set.
- R6: A stream instruction in decode stalls when any of M0 to M3 holds a load, store, divide or floating-point instruction whose exception flag is set. Multiply there does not stall it.
- R7: A load or store in M0 with a load, store, divide or floating-point instruction in M1, M2 or M3 whose exception flag is set raises `hold_m0`, `bubble_m1`, `hold_ex` and `stall_front`. `bubble_ex` and `bubble_m0` stay low.
- R8: With the exception flag clear, the structural interlocks of R5, R6 and R7 do not fire.
- R9: A divide or long floating-point instruction arriving in EX keeps `hold_ex`, `bubble_m0` and `stall_front` high for MC_LAT-1 cycles and releases them in its MC_LAT-th cycle.
- R10: Reset clears the busy count. After reset, with bubbles everywhere, all outputs are low, and a multi-cycle instruction in EX again holds for MC_LAT-1 cycles.
- R11: A second multi-cycle instruction entering EX right after the first releases receives its own full MC_LAT-1 cycle hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| of_src_a | input | REG_AW | First source register of the decode instruction |
| of_src_b | input | REG_AW | Second source register of the decode instruction |
| of_cat | input | 4 | Category of the decode instruction |
| dn_dst | input | 5 x REG_AW | Destination register per downstream stage (index 0 = EX) |
| dn_we | input | 5 | Register write-enable per downstream stage |
| dn_cat | input | 5 x 4 | Category per downstream stage |
| dn_exc | input | 5 | Exception-enable flag per downstream stage |
| stall_front | output | 1 | Freeze fetch and decode |
| bubble_ex | output | 1 | Send a no-op into EX |
| hold_ex | output | 1 | Freeze the EX stage |
| bubble_m0 | output | 1 | Send a no-op into M0 |
| hold_m0 | output | 1 | Freeze M0 and every earlier stage |
| bubble_m1 | output | 1 | Send a no-op into M1 |

## Verification
The assertions assume the surrounding pipeline obeys the controls. An instruction held in EX keeps the same category on `dn_cat[0]` until `hold_ex` drops, and a bubble is presented as category ALU with write-enable low. The bench respects this. It keeps the downstream inputs constant across every held cycle of a multi-cycle operation, changes EX contents only in the cycle after a release, and drives every unused stage as a write-disabled ALU bubble with the exception flag clear.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int REG_AW = 5,
  parameter int MC_LAT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_AW-1:0]      of_src_a,
  input  logic [REG_AW-1:0]      of_src_b,
  input  logic [3:0]             of_cat,
  input  logic [4:0][REG_AW-1:0] dn_dst,
  input  logic [4:0]             dn_we,
  input  logic [4:0][3:0]        dn_cat,
  input  logic [4:0]             dn_exc,
  output logic                   stall_front,
  output logic                   bubble_ex,
  output logic                   hold_ex,
  output logic                   bubble_m0,
  output logic                   hold_m0,
  output logic                   bubble_m1
);
  localparam logic [3:0] C_ALU = 4'd0, C_SHF = 4'd1, C_MUL = 4'd2, C_LD = 4'd3, C_ST = 4'd4,
                         C_DIV = 4'd5, C_FP = 4'd6, C_FPL = 4'd7, C_STRM = 4'd8;
  localparam int CNT_W = $clog2(MC_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MC_LAT - 1);

  function automatic logic [2:0] avail(input logic [3:0] c);
    case (c)
      C_SHF, C_ST:               avail = 3'd1;
      C_MUL:                     avail = 3'd2;
      C_LD, C_DIV, C_FP, C_FPL:  avail = 3'd5;
      default:                   avail = 3'd0;
    endcase
  endfunction

  function automatic logic exc_kind(input logic [3:0] c);
    exc_kind = (c == C_LD) || (c == C_ST) || (c == C_DIV) || (c == C_FP) || (c == C_FPL);
  endfunction

  logic [4:0]       raw_s, exc_s;
  logic [CNT_W-1:0] cnt;
  logic             mc_hold, strm_hit, ex_exc_hit;

  for (genvar s = 0; s < 5; s++) begin : g_stage
    assign raw_s[s] = dn_we[s] && (dn_dst[s] != '0) &&
                      ((dn_dst[s] == of_src_a) || (dn_dst[s] == of_src_b)) &&
                      (3'(s) < avail(dn_cat[s]));
    assign exc_s[s] = dn_exc[s] && exc_kind(dn_cat[s]);
  end

  assign ex_exc_hit  = exc_s[0] || (dn_exc[0] && dn_cat[0] == C_STRM);
  assign strm_hit    = (of_cat == C_STRM) && (ex_exc_hit || (|exc_s[4:1]));
  assign hold_m0     = ((dn_cat[1] == C_LD) || (dn_cat[1] == C_ST)) && (|exc_s[4:2]);
  assign mc_hold     = ((dn_cat[0] == C_DIV) || (dn_cat[0] == C_FPL)) && (cnt != CNT_LAST);
  assign hold_ex     = mc_hold || hold_m0;
  assign stall_front = (|raw_s) || strm_hit || hold_ex;
  assign bubble_ex   = stall_front && !hold_ex;
  assign bubble_m0   = mc_hold && !hold_m0;
  assign bubble_m1   = hold_m0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (mc_hold)  cnt <= cnt + 1'b1;
    else if (!hold_m0) cnt <= '0;
  end
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int REG_AW = 5,
  parameter int MC_LAT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [REG_AW-1:0]      of_src_a,
  input logic [REG_AW-1:0]      of_src_b,
  input logic [3:0]             of_cat,
  input logic [4:0][3:0]        dn_cat,
  input logic [4:0]             dn_exc,
  input logic                   stall_front,
  input logic                   bubble_ex,
  input logic                   hold_ex,
  input logic                   bubble_m0,
  input logic                   hold_m0,
  input logic                   bubble_m1
);
  localparam int RW = $clog2(MC_LAT + 1);
  logic          fresh;
  logic [RW-1:0] run;
  logic          mc_in_ex, ex_exc;

  assign mc_in_ex = (dn_cat[0] == 4'd5) || (dn_cat[0] == 4'd7);
  assign ex_exc   = dn_exc[0] && (dn_cat[0] >= 4'd3) && (dn_cat[0] != 4'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b1;
      run   <= '0;
    end else begin
      fresh <= !hold_ex;
      if (hold_ex && !hold_m0) run <= (run == RW'(MC_LAT)) ? run : run + 1'b1;
      else                     run <= '0;
    end
  end

  a_r4_bubble_only_when_ex_free: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> stall_front && !hold_ex);
  a_r7_m0_freeze_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    hold_m0 |-> hold_ex && stall_front && bubble_m1 && !bubble_m0 && !bubble_ex);
  a_r9_mc_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_in_ex && fresh && MC_LAT > 1) |-> hold_ex && bubble_m0);
  a_r9_mc_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ex && !hold_m0) |-> (run < RW'(MC_LAT - 1)));
  a_r5_stream_behind_ex: assert property (@(posedge clk) disable iff (!rst_n)
    (of_cat == 4'd8 && ex_exc) |-> stall_front);
  a_r2_no_sources_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (of_src_a == '0 && of_src_b == '0 && of_cat != 4'd8 && !hold_ex) |-> !stall_front);
endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_AW(REG_AW), .MC_LAT(MC_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .of_src_a(of_src_a), .of_src_b(of_src_b), .of_cat(of_cat),
  .dn_cat(dn_cat), .dn_exc(dn_exc), .stall_front(stall_front), .bubble_ex(bubble_ex),
  .hold_ex(hold_ex), .bubble_m0(bubble_m0), .hold_m0(hold_m0), .bubble_m1(bubble_m1));

// File: tb/pipe_interlock_tb_top.sv
module pipe_interlock_tb_top;
  localparam int AW = 5;
  localparam int MCL = 4;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] of_src_a, of_src_b;
  logic [3:0] of_cat;
  logic [4:0][AW-1:0] dn_dst;
  logic [4:0] dn_we, dn_exc;
  logic [4:0][3:0] dn_cat;
  logic stall_front, bubble_ex, hold_ex, bubble_m0, hold_m0, bubble_m1;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pipe_interlock #(.REG_AW(AW), .MC_LAT(MCL)) dut_i (.*);

  // req, of_cat, src_a, src_b, stage, producer cat, dst, we, exc, expected stall
  localparam logic [32:0] VEC [NV] = '{
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd0, 4'd1, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 shift in EX
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd1, 4'd1, 5'd3, 1'b1, 1'b0, 1'b0}, // R1 shift in M0
    {4'd3, 4'd0, 5'd3, 5'd4, 3'd0, 4'd2, 5'd4, 1'b1, 1'b0, 1'b1}, // R3 mul EX on src b
    {4'd3, 4'd0, 5'd3, 5'd4, 3'd1, 4'd2, 5'd4, 1'b1, 1'b0, 1'b1}, // R3 mul M0 on src b
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd2, 4'd2, 5'd4, 1'b1, 1'b0, 1'b0}, // R1 mul M1
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd4, 4'd3, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 load M3
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd2, 4'd3, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 load M1
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd0, 4'd4, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 store EX
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd1, 4'd4, 5'd3, 1'b1, 1'b0, 1'b0}, // R1 store M0
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd0, 4'd0, 5'd3, 1'b1, 1'b0, 1'b0}, // R1 ALU EX
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd3, 4'd6, 5'd4, 1'b1, 1'b0, 1'b1}, // R1 fp M2
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd4, 4'd6, 5'd4, 1'b1, 1'b0, 1'b1}, // R1 fp M3
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd0, 4'd6, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 fp EX
    {4'd3, 4'd0, 5'd3, 5'd4, 3'd3, 4'd3, 5'd5, 1'b1, 1'b0, 1'b0}, // R3 no match
    {4'd2, 4'd0, 5'd3, 5'd4, 3'd1, 4'd3, 5'd3, 1'b0, 1'b0, 1'b0}, // R2 we low
    {4'd2, 4'd0, 5'd0, 5'd4, 3'd1, 4'd3, 5'd0, 1'b1, 1'b0, 1'b0}, // R2 r0
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd2, 4'd5, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 div M1
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd4, 4'd5, 5'd4, 1'b1, 1'b0, 1'b1}, // R1 div M3
    {4'd1, 4'd0, 5'd3, 5'd4, 3'd3, 4'd7, 5'd3, 1'b1, 1'b0, 1'b1}, // R1 long fp M2
    {4'd5, 4'd8, 5'd0, 5'd0, 3'd0, 4'd3, 5'd0, 1'b0, 1'b1, 1'b1}, // R5 load EX exc
    {4'd8, 4'd8, 5'd0, 5'd0, 3'd0, 4'd3, 5'd0, 1'b0, 1'b0, 1'b0}, // R8 load EX no exc
    {4'd5, 4'd8, 5'd0, 5'd0, 3'd0, 4'd8, 5'd0, 1'b0, 1'b1, 1'b1}, // R5 stream EX exc
    {4'd6, 4'd8, 5'd0, 5'd0, 3'd3, 4'd5, 5'd0, 1'b0, 1'b1, 1'b1}, // R6 div M2 exc
    {4'd6, 4'd8, 5'd0, 5'd0, 3'd4, 4'd4, 5'd0, 1'b0, 1'b1, 1'b1}, // R6 store M3 exc
    {4'd6, 4'd8, 5'd0, 5'd0, 3'd2, 4'd2, 5'd0, 1'b0, 1'b1, 1'b0}, // R6 mul M1 exc
    {4'd8, 4'd8, 5'd0, 5'd0, 3'd1, 4'd6, 5'd0, 1'b0, 1'b0, 1'b0}, // R8 fp M0 no exc
    {4'd5, 4'd0, 5'd0, 5'd0, 3'd0, 4'd4, 5'd0, 1'b0, 1'b1, 1'b0}  // R5 non-stream decode
  };

  function automatic logic [5:0] outs();
    return {stall_front, bubble_ex, hold_ex, bubble_m0, hold_m0, bubble_m1};
  endfunction

  task automatic chk(input string req, input string what, input logic [5:0] exp);
    logic [5:0] act;
    act = outs();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    of_src_a = '0; of_src_b = '0; of_cat = 4'd0;
    dn_dst = '0; dn_we = '0; dn_cat = '0; dn_exc = '0;
  endtask

  task automatic put(input int s, input logic [3:0] c, input logic [AW-1:0] d,
                     input logic we, input logic ex);
    dn_cat[s] = c; dn_dst[s] = d; dn_we[s] = we; dn_exc[s] = ex;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R10", "reset idle", 6'b000000);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      @(negedge clk);
      idle();
      of_cat = v[28:25]; of_src_a = v[24:20]; of_src_b = v[19:15];
      put(int'(v[14:12]), v[11:8], v[7:3], v[2], v[1]);
      #1 chk($sformatf("R%0d", v[32:29]), $sformatf("vector %0d", i),
             {v[0], v[0], 4'b0000});
    end

    // R7: load in M0 behind an excepting divide in M2
    @(negedge clk); idle();
    put(1, 4'd3, 5'd9, 1'b1, 1'b0); put(3, 4'd5, 5'd0, 1'b0, 1'b1);
    #1 chk("R7", "load M0, div M2 exc", 6'b101011);
    @(negedge clk); idle();
    put(1, 4'd4, 5'd0, 1'b0, 1'b0); put(2, 4'd6, 5'd0, 1'b0, 1'b1);
    #1 chk("R7", "store M0, fp M1 exc", 6'b101011);
    @(negedge clk); idle();
    put(1, 4'd3, 5'd0, 1'b0, 1'b0); put(4, 4'd3, 5'd0, 1'b0, 1'b0);
    #1 chk("R8", "load M0, load M3 no exc", 6'b000000);
    @(negedge clk); idle();
    put(1, 4'd2, 5'd0, 1'b0, 1'b0); put(2, 4'd3, 5'd0, 1'b0, 1'b1);
    #1 chk("R7", "mul M0 is not a memory op", 6'b000000);

    // R9: divide held in EX, then R11: long fp right behind it
    @(negedge clk); idle();
    of_src_a = 5'd1; of_src_b = 5'd2; put(0, 4'd5, 5'd7, 1'b1, 1'b0);
    for (int c = 1; c <= MCL; c++) begin
      if (c > 1) @(negedge clk);
      #1 chk("R9", $sformatf("divide cycle %0d", c), (c < MCL) ? 6'b101100 : 6'b000000);
    end
    @(negedge clk); put(0, 4'd7, 5'd8, 1'b1, 1'b0);
    for (int c = 1; c <= MCL; c++) begin
      if (c > 1) @(negedge clk);
      #1 chk("R11", $sformatf("back-to-back cycle %0d", c), (c < MCL) ? 6'b101100 : 6'b000000);
    end

    // R10: reset during a hold restarts the count
    @(negedge clk); put(0, 4'd5, 5'd7, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int c = 1; c <= MCL; c++) begin
      if (c > 1) @(negedge clk);
      #1 chk("R10", $sformatf("hold after reset cycle %0d", c), (c < MCL) ? 6'b101100 : 6'b000000);
    end

    // R4: data stall while EX is busy gives no EX bubble
    @(negedge clk); idle();
    of_src_a = 5'd6; put(0, 4'd7, 5'd0, 1'b0, 1'b0); put(2, 4'd3, 5'd6, 1'b1, 1'b0);
    #1 chk("R4", "data stall under multi-cycle hold", 6'b101100);
    repeat (MCL) @(negedge clk);
    idle();
    #1 chk("R4", "idle after hold", 6'b000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule